// File: doc/BRIEF.md
# Scalar Shift-and-Insert Execute Unit

This unit executes one class of 32-bit scalar instructions that move a 64-bit source value by an immediate amount and merge it into an existing 64-bit destination value. Two directions exist: insert-after-left-shift and insert-after-right-shift. The shifted source replaces only the destination bits it covers. Every other destination bit is kept. The unit decodes the instruction word itself, checks for reserved or unknown encodings, derives the shift amount and the merge mask, and produces the merged value.

The caller supplies the instruction word and both operand values, then raises a valid strobe. One cycle later the unit presents four things: the result, the destination register index, a write-enable for the register file, and a flag that marks the word as undefined. Register reads, hazard handling and element sizes other than 64 bits belong to the surrounding pipeline.

Top module: `shift_insert_unit`

## Requirements
- R1: A word is recognised only when bits [31:23] equal 011111110 and bits [15:10] equal 010001 (right insert) or 010101 (left insert). Any other accepted word gives out_undef=1 and out_wen=0.
- R2: A recognised word whose bit 22 is 0 is reserved. It gives out_undef=1 and out_wen=0.
- R3: For right insert, let imm = bit 22 down to bit 16 taken as an unsigned number (64..127) and amount = 128 - imm. Result bit i is src[i+amount] when i+amount < 64, and dst[i] otherwise.
- R4: A right insert with imm = 64 (amount 64) returns the destination value unchanged.
- R5: For left insert, amount = imm - 64 (0..63). Result bit i is src[i-amount] when i >= amount, and dst[i] otherwise.
- R6: A left insert with imm = 64 (amount 0) returns the source value unchanged.
- R7: out_valid is high exactly one cycle after in_valid is high. A cycle without in_valid gives all outputs zero in the next cycle.
- R8: While rst_n is low at a clock edge, all outputs are zero after that edge. The reset is synchronous and active-low.
- R9: An accepted word that is undefined (R1 or R2) gives out_result equal to zero.
- R10: An accepted legal word gives out_wen=1 and out_undef=0. For every accepted word, out_rd equals bits [4:0] of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word and operands are present this cycle |
| insn | input | 32 | Instruction word |
| src_val | input | 64 | Source operand value |
| dst_val | input | 64 | Current destination value |
| out_valid | output | 1 | Registered result is present |
| out_result | output | 64 | Merged result |
| out_rd | output | 5 | Destination register index |
| out_wen | output | 1 | Write the result to the register file |
| out_undef | output | 1 | Word was reserved or not recognised |

## Verification
The bench builds the unit with SHIFT_IMPL=1, which selects the staged shift network rather than the plain shift operator. Under that setting, sweeping all 64 immediates in each direction drives every stage enable, including the 64-position stage that only the right-by-64 case uses. The bench also sends words that differ from a legal word in the prefix, in the opcode or in bit 22. It presents idle cycles and applies reset in the middle of a run, so that the undefined path and the output-clearing path are both covered.

// File: rtl/shins_pkg.sv
package shins_pkg;

   typedef enum logic {
      DIR_LEFT  = 1'b0,
      DIR_RIGHT = 1'b1
   } shdir_e;

   localparam logic [8:0] HEAD_CODE = 9'b011111110;
   localparam logic [5:0] OPC_RINS  = 6'b010001;
   localparam logic [5:0] OPC_LINS  = 6'b010101;

endpackage

// File: rtl/shins_shifter.sv
module shins_shifter
   import shins_pkg::*;
#(
   parameter int W          = 64,
   parameter int AMT_W      = 7,
   parameter int SHIFT_IMPL = 0
) (
   input  logic [W-1:0]     din,
   input  logic [AMT_W-1:0] amt,
   input  shdir_e           dir,
   output logic [W-1:0]     dout
);

   generate
      if (SHIFT_IMPL == 0) begin : g_operator
         assign dout = (dir == DIR_RIGHT) ? (din >> amt) : (din << amt);
      end else begin : g_staged
         logic [W-1:0] stg [AMT_W+1];
         assign stg[0] = din;
         for (genvar k = 0; k < AMT_W; k++) begin : g_stage
            localparam int SH = 1 << k;
            assign stg[k+1] = !amt[k] ? stg[k] :
                              ((dir == DIR_RIGHT) ? (stg[k] >> SH) : (stg[k] << SH));
         end
         assign dout = stg[AMT_W];
      end
   endgenerate

endmodule

// File: rtl/shins_mask.sv
module shins_mask
   import shins_pkg::*;
#(
   parameter int W          = 64,
   parameter int AMT_W      = 7,
   parameter int SHIFT_IMPL = 0
) (
   input  logic [AMT_W-1:0] amt,
   input  shdir_e           dir,
   output logic [W-1:0]     mask
);

   localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(W);

   logic [W-1:0] raw_mask;

   shins_shifter #(
      .W          (W),
      .AMT_W      (AMT_W),
      .SHIFT_IMPL (SHIFT_IMPL)
   ) u_mask_sh (
      .din  ({W{1'b1}}),
      .amt  (amt),
      .dir  (dir),
      .dout (raw_mask)
   );

   // A full-width right move covers no destination bit at all.
   assign mask = (dir == DIR_RIGHT && amt == FULL_AMT) ? '0 : raw_mask;

endmodule

// File: rtl/shins_decode.sv
module shins_decode
   import shins_pkg::*;
#(
   parameter int INSN_W = 32,
   parameter int REG_W  = 5,
   parameter int AMT_W  = 7
) (
   input  logic [INSN_W-1:0] insn,
   output logic              legal,
   output shdir_e            dir,
   output logic [AMT_W-1:0]  amt,
   output logic [REG_W-1:0]  rd
);

   localparam logic [AMT_W:0]   RIGHT_BASE = (AMT_W+1)'(2 ** AMT_W);
   localparam logic [AMT_W-1:0] LEFT_BASE  = AMT_W'(2 ** (AMT_W-1));

   logic [8:0]       head;
   logic [5:0]       opc;
   logic [AMT_W-1:0] imm;
   logic             is_r, is_l;
   logic [REG_W-1:0] rn_field;
   logic             unused_rn;

   assign head     = insn[31:23];
   assign imm      = insn[22:16];
   assign opc      = insn[15:10];
   assign rn_field = insn[9:5];
   assign rd       = insn[REG_W-1:0];

   // The source index is resolved by the register-read stage, not here.
   assign unused_rn = ^rn_field;

   assign is_r  = (head == HEAD_CODE) && (opc == OPC_RINS);
   assign is_l  = (head == HEAD_CODE) && (opc == OPC_LINS);
   assign legal = (is_r || is_l) && imm[AMT_W-1];
   assign dir   = is_r ? DIR_RIGHT : DIR_LEFT;

   always_comb begin
      if (is_r) amt = AMT_W'(RIGHT_BASE - {1'b0, imm});
      else      amt = imm - LEFT_BASE;
   end

endmodule

// File: rtl/shift_insert_unit.sv
module shift_insert_unit
   import shins_pkg::*;
#(
   parameter int ELEM_W     = 64,
   parameter int INSN_W     = 32,
   parameter int REG_W      = 5,
   parameter int SHIFT_IMPL = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [31:0]       insn,
   input  logic [63:0]       src_val,
   input  logic [63:0]       dst_val,
   output logic              out_valid,
   output logic [63:0]       out_result,
   output logic [4:0]        out_rd,
   output logic              out_wen,
   output logic              out_undef
);

   localparam int AMT_W = $clog2(ELEM_W) + 1;

   generate
      if (ELEM_W != 64) begin : g_bad_elem
         $error("shift_insert_unit: encoding fixes the element width at 64");
      end
      if (INSN_W != 32) begin : g_bad_insn
         $error("shift_insert_unit: instruction word must be 32 bits");
      end
      if (REG_W != 5) begin : g_bad_reg
         $error("shift_insert_unit: register index field is 5 bits");
      end
      if (SHIFT_IMPL != 0 && SHIFT_IMPL != 1) begin : g_bad_impl
         $error("shift_insert_unit: SHIFT_IMPL must be 0 or 1");
      end
   endgenerate

   logic              legal;
   shdir_e            dir;
   logic [AMT_W-1:0]  amt;
   logic [REG_W-1:0]  rd;
   logic [ELEM_W-1:0] moved, mask, merged;

   shins_decode #(
      .INSN_W (INSN_W),
      .REG_W  (REG_W),
      .AMT_W  (AMT_W)
   ) u_decode (
      .insn  (insn),
      .legal (legal),
      .dir   (dir),
      .amt   (amt),
      .rd    (rd)
   );

   shins_shifter #(
      .W          (ELEM_W),
      .AMT_W      (AMT_W),
      .SHIFT_IMPL (SHIFT_IMPL)
   ) u_data_sh (
      .din  (src_val),
      .amt  (amt),
      .dir  (dir),
      .dout (moved)
   );

   shins_mask #(
      .W          (ELEM_W),
      .AMT_W      (AMT_W),
      .SHIFT_IMPL (SHIFT_IMPL)
   ) u_mask (
      .amt  (amt),
      .dir  (dir),
      .mask (mask)
   );

   assign merged = (dst_val & ~mask) | moved;

   always_ff @(posedge clk) begin
      if (!rst_n || !in_valid) begin
         out_valid  <= 1'b0;
         out_result <= '0;
         out_rd     <= '0;
         out_wen    <= 1'b0;
         out_undef  <= 1'b0;
      end else begin
         out_valid  <= 1'b1;
         out_result <= legal ? merged : '0;
         out_rd     <= rd;
         out_wen    <= legal;
         out_undef  <= !legal;
      end
   end

endmodule

// File: rtl/shins_chk.sv
module shins_chk
   import shins_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [31:0] insn,
   input logic [63:0] src_val,
   input logic [63:0] dst_val,
   input logic        out_valid,
   input logic [63:0] out_result,
   input logic [4:0]  out_rd,
   input logic        out_wen,
   input logic        out_undef
);

   logic known_op;
   assign known_op = (insn[31:23] == HEAD_CODE) &&
                     (insn[15:10] == OPC_RINS || insn[15:10] == OPC_LINS);

   assert_reset_clear_R8: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && !out_wen && !out_undef && out_result == '0 && out_rd == '0));

   assert_valid_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !out_wen && !out_undef));

   assert_flag_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_wen ^ out_undef));

   assert_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && known_op && !insn[22]) |=> (out_undef && !out_wen));

   assert_right64_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && insn[31:23] == HEAD_CODE && insn[15:10] == OPC_RINS && insn[22:16] == 7'd64)
      |=> (out_result == $past(dst_val)));

   assert_left0_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && insn[31:23] == HEAD_CODE && insn[15:10] == OPC_LINS && insn[22:16] == 7'd64)
      |=> (out_result == $past(src_val)));

   assert_undef_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_undef |-> (out_result == '0));

   assert_rd_track_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_rd == $past(insn[4:0])));

endmodule

bind shift_insert_unit shins_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .insn       (insn),
   .src_val    (src_val),
   .dst_val    (dst_val),
   .out_valid  (out_valid),
   .out_result (out_result),
   .out_rd     (out_rd),
   .out_wen    (out_wen),
   .out_undef  (out_undef)
);

// File: tb/shift_insert_unit_bench.sv
`timescale 1ns/1ps
module shift_insert_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [31:0] insn;
   logic [63:0] src_val, dst_val;
   logic        out_valid, out_wen, out_undef;
   logic [63:0] out_result;
   logic [4:0]  out_rd;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #2.5 clk = ~clk;

   shift_insert_unit #(.SHIFT_IMPL(1)) u_shift_insert_unit (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .insn       (insn),
      .src_val    (src_val),
      .dst_val    (dst_val),
      .out_valid  (out_valid),
      .out_result (out_result),
      .out_rd     (out_rd),
      .out_wen    (out_wen),
      .out_undef  (out_undef)
   );

   function automatic logic [31:0] mk(input bit right, input logic [6:0] imm,
                                      input logic [4:0] rn, input logic [4:0] rd);
      return {9'b011111110, imm, (right ? 6'b010001 : 6'b010101), rn, rd};
   endfunction

   function automatic logic [63:0] rnd64();
      return {$urandom, $urandom};
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   // Apply one cycle of stimulus (called just after a falling edge),
   // predict the registered outputs and compare at the next falling edge.
   task automatic step(input bit rst, input bit vld, input logic [31:0] w,
                       input logic [63:0] s, input logic [63:0] d, input string tag);
      logic        e_valid, e_wen, e_undef, lgl, right;
      logic [63:0] e_res;
      logic [4:0]  e_rd;
      int          imm, amt;
      rst_n = rst; in_valid = vld; insn = w; src_val = s; dst_val = d;
      e_valid = 0; e_wen = 0; e_undef = 0; e_res = '0; e_rd = '0;
      right = (w[15:10] == 6'b010001);
      lgl = (w[31:23] == 9'b011111110) &&
            (w[15:10] == 6'b010001 || w[15:10] == 6'b010101) && w[22];
      if (rst && vld) begin
         e_valid = 1; e_rd = w[4:0]; e_wen = lgl; e_undef = !lgl;
         if (lgl) begin
            imm = int'(w[22:16]);
            amt = right ? (128 - imm) : (imm - 64);
            for (int i = 0; i < 64; i++) begin
               if (right) e_res[i] = (i + amt < 64) ? s[i + amt] : d[i];
               else       e_res[i] = (i >= amt)     ? s[i - amt] : d[i];
            end
         end
      end
      @(negedge clk);
      chk(tag, "valid",  {63'b0, out_valid}, {63'b0, e_valid});
      chk(tag, "wen",    {63'b0, out_wen},   {63'b0, e_wen});
      chk(tag, "undef",  {63'b0, out_undef}, {63'b0, e_undef});
      chk(tag, "rd",     {59'b0, out_rd},    {59'b0, e_rd});
      chk(tag, "result", out_result,         e_res);
   endtask

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; insn = '0; src_val = '0; dst_val = '0;
      @(negedge clk);
      // R8: reset clears outputs even with a legal valid word present
      for (int k = 0; k < 3; k++)
         step(0, 1, mk(1, 7'd100, 5'd1, 5'd9), rnd64(), rnd64(), "R8");
      // R7: idle cycle
      step(1, 0, mk(0, 7'd70, 5'd2, 5'd3), rnd64(), rnd64(), "R7");
      // R4 / R6: boundary amounts
      step(1, 1, mk(1, 7'd64, 5'd0, 5'd4), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF, "R4");
      step(1, 1, mk(0, 7'd64, 5'd0, 5'd5), 64'hDEAD_BEEF_0BAD_F00D, 64'hFFFF_0000_FFFF_0000, "R6");
      // R3: every right amount
      for (int im = 64; im < 128; im++)
         step(1, 1, mk(1, 7'(im), 5'(im), 5'(im + 3)), rnd64(), rnd64(), "R3");
      // R5: every left amount
      for (int im = 64; im < 128; im++)
         step(1, 1, mk(0, 7'(im), 5'(im), 5'(im + 7)), rnd64(), rnd64(), "R5");
      // R3/R5 extremes with all-ones and all-zeros operands
      step(1, 1, mk(1, 7'd127, 5'd1, 5'd1), '0, '1, "R3");
      step(1, 1, mk(0, 7'd127, 5'd1, 5'd2), '1, '0, "R5");
      // R2: reserved immediates in both directions
      step(1, 1, mk(1, 7'd63, 5'd1, 5'd10), rnd64(), rnd64(), "R2");
      step(1, 1, mk(0, 7'd0,  5'd1, 5'd11), rnd64(), rnd64(), "R2");
      step(1, 1, mk(0, 7'd35, 5'd1, 5'd12), rnd64(), rnd64(), "R2");
      // R1 / R9: unrecognised prefix and opcode
      step(1, 1, mk(1, 7'd90, 5'd1, 5'd13) ^ 32'h0080_0000, rnd64(), rnd64(), "R1");
      step(1, 1, mk(0, 7'd90, 5'd1, 5'd14) ^ 32'h8000_0000, rnd64(), rnd64(), "R1");
      step(1, 1, {9'b011111110, 7'd90, 6'b010011, 5'd1, 5'd15}, rnd64(), rnd64(), "R9");
      step(1, 1, {9'b011111110, 7'd90, 6'b000000, 5'd1, 5'd16}, rnd64(), rnd64(), "R9");
      // R10 / R7: back-to-back, then idle, then mid-run reset (R8)
      step(1, 1, mk(1, 7'd80, 5'd3, 5'd31), rnd64(), rnd64(), "R10");
      step(1, 1, mk(0, 7'd80, 5'd3, 5'd0),  rnd64(), rnd64(), "R10");
      step(1, 0, mk(0, 7'd80, 5'd3, 5'd7),  rnd64(), rnd64(), "R7");
      step(0, 1, mk(0, 7'd81, 5'd3, 5'd7),  rnd64(), rnd64(), "R8");
      step(1, 1, mk(1, 7'd81, 5'd3, 5'd6),  rnd64(), rnd64(), "R10");
      // Mixed random traffic
      for (int k = 0; k < 300; k++) begin
         logic [31:0] w;
         w = mk($urandom_range(0, 1) == 1, 7'($urandom), 5'($urandom), 5'($urandom));
         if ($urandom_range(0, 7) == 0) w = $urandom;
         step(1, $urandom_range(0, 5) != 0, w, rnd64(), rnd64(), "R3");
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R7 watchdog: got no completion expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule